// File: doc/BRIEF.md
# Converter Control and Byte-Bus Interface

This block is the digital controller of a 12-bit successive-approximation converter. It runs on the master clock and sequences every conversion and calibration. A rising edge on the start input captures the sampled level and runs a conversion of fixed length. During the conversion the block resolves one result bit per cycle against a behavioural comparator stub. It then loads the formatted code into the result register and holds BUSY high until the last cycle. A write to the control register can also start one of three calibration sequences. Each sequence has its own cycle count, and BUSY covers the whole of it. The analog parts are not part of the block. Pad-level tri-stating sits outside: the block supplies output data and two output-enable signals.

Host access goes through chip select, read, write and a high-byte-enable strobe. Writes arrive as two bytes and commit as one 16-bit word. Bits [15:14] of that word pick the destination register. A read with the high-byte-enable low returns 12 bits at once. A read with it high returns the upper byte, so the 14-bit calibration registers need two reads.

Top module: `sar_bytebus_ctrl`

## Requirements
- R1: A rising edge of `convst` sampled while BUSY is low starts a conversion. BUSY is high from the following clock edge.
- R2: A conversion keeps BUSY high for exactly `CONV_CYCLES` (default 18) clock cycles.
- R3: The new result is readable at least one full clock cycle before BUSY falls.
- R4: In unipolar mode (control bit 2 = 0) the result equals the captured sample code. In bipolar mode (bit 2 = 1) it is the same code with its MSB inverted, which gives two's complement about mid-scale.
- R5: A read with `hben`=0 puts the low 12 bits of the selected register on `db_out[11:0]` and raises both enables. A read with `hben`=1 puts bits [15:8] on `db_out[7:0]`, with `db_out[11:8]`=0 and `db_oe_upper` low.
- R6: Neither enable is high unless `cs_n` and `rd_n` are both low.
- R7: A register write is a low byte (`hben`=0) followed by a high byte (`hben`=1). The word commits only when the high byte arrives. Word bits [15:14] select the destination: 00 control, 10 offset calibration, 11 gain calibration, 01 discarded. The payload is bits [13:0].
- R8: A high byte with no pending low byte changes no register. A second low byte replaces the pending one.
- R9: Control fields: [1:0] read pointer (00 control, 01 result, 10 offset calibration, 11 gain calibration), [2] bipolar, [4:3] calibration mode. A control read returns these 5 bits, zero-extended. The calibration registers hold 14 bits.
- R10: A committed control write with a nonzero calibration mode raises BUSY one clock after the commit edge. BUSY then stays high for `CAL_FULL_CYC` cycles (mode 01, full self-calibration), `CAL_FSG_CYC` cycles (mode 10, DAC plus full-scale) or `CAL_OFS_CYC` cycles (mode 11, system offset).
- R11: The calibration mode field reads 00 from the edge on which BUSY falls at the end of a calibration.
- R12: `convst` edges while BUSY is high, during a conversion or a calibration, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| convst | input | 1 | Convert start, rising-edge active |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hben | input | 1 | High-byte enable |
| db_in | input | 8 | Write data byte |
| sample_code | input | RES_W | Level presented by the analog stub, captured at conversion start |
| busy | output | 1 | Conversion or calibration in progress |
| db_out | output | RES_W | Read data |
| db_oe_byte | output | 1 | Drive enable for db_out[7:0] |
| db_oe_upper | output | 1 | Drive enable for db_out[RES_W-1:8] |

## Verification
The bench sweeps sample codes across the full range in both number formats, including the codes at mid-scale and at each end. A SAR with a wrong bit order, or a missed MSB inversion, shows up as a wrong code there. It reads the result during the last BUSY cycle, so a load placed too late reads as stale data. It also counts BUSY cycles for conversions and for each calibration mode. A counter that is off by one, or a start that fires on the commit edge instead of the next edge, changes those counts. Other tests send a lone high byte, two low bytes in a row, and writes to the reserved destination. They also toggle `convst` during BUSY. A faulty byte assembler would corrupt a register, and a faulty edge filter would restart the count or replace the result.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int PAY_W  = 14;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_RES  = 2'd1,
        REG_OFS  = 2'd2,
        REG_GAIN = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CM_NONE = 2'd0,
        CM_FULL = 2'd1,
        CM_FSG  = 2'd2,
        CM_OFS  = 2'd3
    } cal_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CONV = 2'd1,
        SQ_CAL  = 2'd2
    } seq_state_e;

    typedef struct packed {
        cal_mode_e cal;
        logic      bipolar;
        reg_sel_e  rptr;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sbc_cmp_stub.sv
module sbc_cmp_stub #(
    parameter int W = 12
) (
    input  logic [W-1:0] trial,
    input  logic [W-1:0] level,
    output logic         keep
);
    // Behavioural comparator: the trial DAC level stays if it does not exceed the held input
    assign keep = (trial <= level);
endmodule

// File: rtl/sbc_sar.sv
module sbc_sar
    import sbc_pkg::*;
#(
    parameter int RES_W = 12,
    localparam int SW = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [RES_W-1:0] sample_code,
    input  logic             step_en,
    input  logic [SW-1:0]    step_pos,
    input  logic             bipolar,
    output logic [RES_W-1:0] res_val
);
    logic [RES_W-1:0] held;
    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] trial;
    logic             keep;

    assign trial = acc | (RES_W'(1) << step_pos);

    sbc_cmp_stub #(.W(RES_W)) u_cmp (
        .trial (trial),
        .level (held),
        .keep  (keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            acc  <= '0;
        end else if (start) begin
            held <= sample_code;
            acc  <= '0;
        end else if (step_en && keep) begin
            acc <= trial;
        end
    end

    // Offset binary to two's complement: flip the MSB
    assign res_val = bipolar ? {~acc[RES_W-1], acc[RES_W-2:0]} : acc;

    // R4: a finished unipolar conversion never exceeds the held level
    p_acc_bound_r4: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (acc <= held));
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int RES_W        = 12,
    parameter int CONV_CYCLES  = 18,
    parameter int CAL_FULL_CYC = 125013,
    parameter int CAL_FSG_CYC  = 111124,
    parameter int CAL_OFS_CYC  = 13889,
    localparam int SW = $clog2(RES_W),
    localparam int CW = $clog2(max3(max3(CAL_FULL_CYC, CAL_FSG_CYC, CAL_OFS_CYC),
                                    CONV_CYCLES, RES_W + 2) + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           convst,
    input  logic           cal_go,
    input  cal_mode_e      cal_mode,
    output logic           busy,
    output logic           conv_start,
    output logic           step_en,
    output logic [SW-1:0]  step_pos,
    output logic           res_load,
    output logic           cal_done
);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);
    localparam logic [CW-1:0] STEPS     = CW'(RES_W);
    localparam logic [SW-1:0] TOPBIT    = SW'(RES_W - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cal_len;
    logic          convst_q;
    logic          rise;
    logic          cal_req;
    logic          res_seen;

    always_comb begin
        case (cal_mode)
            CM_FULL: cal_len = CW'(CAL_FULL_CYC - 1);
            CM_FSG:  cal_len = CW'(CAL_FSG_CYC - 1);
            CM_OFS:  cal_len = CW'(CAL_OFS_CYC - 1);
            default: cal_len = '0;
        endcase
    end

    assign rise       = convst && !convst_q;
    assign cal_req    = cal_go && (cal_mode != CM_NONE);
    assign conv_start = (state == SQ_IDLE) && rise && !cal_req;
    assign busy       = (state != SQ_IDLE);
    assign step_en    = (state == SQ_CONV) && (cnt < STEPS);
    assign step_pos   = TOPBIT - cnt[SW-1:0];
    assign res_load   = (state == SQ_CONV) && (cnt == STEPS);
    assign cal_done   = (state == SQ_CAL) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cnt      <= '0;
            convst_q <= 1'b0;
            res_seen <= 1'b0;
        end else begin
            convst_q <= convst;
            if (conv_start)    res_seen <= 1'b0;
            else if (res_load) res_seen <= 1'b1;
            case (state)
                SQ_IDLE: begin
                    if (cal_req) begin
                        state <= SQ_CAL;
                        cnt   <= cal_len;
                    end else if (rise) begin
                        state <= SQ_CONV;
                        cnt   <= '0;
                    end
                end
                SQ_CONV: begin
                    if (cnt == CONV_LAST) begin
                        state <= SQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                SQ_CAL: begin
                    if (cnt == '0) state <= SQ_IDLE;
                    else           cnt   <= cnt - CW'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R2: the last conversion cycle ends BUSY
    p_conv_len_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CONV && cnt == CONV_LAST) |=> !busy);

    // R12: a running conversion always advances and never restarts
    p_no_restart_r12: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CONV && cnt != CONV_LAST) |=> (state == SQ_CONV && cnt == $past(cnt) + CW'(1)));

    // R3: the result is loaded before the final BUSY cycle
    p_result_early_r3: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_CONV && cnt == CONV_LAST) |-> res_seen);

    // R10: a calibration request from idle enters the calibration state next cycle
    p_cal_follow_r10: assert property (@(posedge clk) disable iff (rst)
        (cal_req && state == SQ_IDLE) |=> (state == SQ_CAL));

    // R10: the calibration countdown end releases BUSY
    p_cal_end_r10: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !busy);
endmodule

// File: rtl/sbc_bytebus.sv
module sbc_bytebus
    import sbc_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             hben,
    input  logic [BYTE_W-1:0] db_in,
    input  logic             res_load,
    input  logic [RES_W-1:0] res_val,
    input  logic             cal_done,
    output ctrl_t            ctrl_q,
    output logic             cal_go,
    output logic [RES_W-1:0] db_out,
    output logic             oe_byte,
    output logic             oe_upper
);
    logic              wr_act, wr_act_q, stb, commit;
    logic [BYTE_W-1:0] lo_buf;
    logic              lo_vld;
    logic [WORD_W-1:0] word;
    logic [1:0]        dest;
    logic [PAY_W-1:0]  pay;
    logic [PAY_W-1:0]  ofs_q, gain_q;
    logic [RES_W-1:0]  res_q;
    logic [WORD_W-1:0] sel;

    assign wr_act = !cs_n && !wr_n;
    assign stb    = wr_act && !wr_act_q;
    assign word   = {db_in, lo_buf};
    assign dest   = word[WORD_W-1:WORD_W-2];
    assign pay    = word[PAY_W-1:0];
    assign commit = stb && hben && lo_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act_q <= 1'b0;
            lo_buf   <= '0;
            lo_vld   <= 1'b0;
            ctrl_q   <= '0;
            ofs_q    <= '0;
            gain_q   <= '0;
            res_q    <= '0;
            cal_go   <= 1'b0;
        end else begin
            wr_act_q <= wr_act;
            cal_go   <= 1'b0;
            if (stb && !hben) begin
                lo_buf <= db_in;
                lo_vld <= 1'b1;
            end else if (commit) begin
                lo_vld <= 1'b0;
                case (dest)
                    2'b00: begin
                        ctrl_q <= ctrl_t'(pay[CTRL_W-1:0]);
                        cal_go <= (pay[CTRL_W-1:CTRL_W-2] != 2'b00);
                    end
                    2'b10:   ofs_q  <= pay;
                    2'b11:   gain_q <= pay;
                    default: ;
                endcase
            end
            if (cal_done) ctrl_q.cal <= CM_NONE;
            if (res_load) res_q <= res_val;
        end
    end

    always_comb begin
        case (ctrl_q.rptr)
            REG_CTRL: sel = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
            REG_RES:  sel = {{(WORD_W-RES_W){1'b0}}, res_q};
            REG_OFS:  sel = {{(WORD_W-PAY_W){1'b0}}, ofs_q};
            default:  sel = {{(WORD_W-PAY_W){1'b0}}, gain_q};
        endcase
    end

    assign db_out   = hben ? {{(RES_W-BYTE_W){1'b0}}, sel[WORD_W-1:BYTE_W]} : sel[RES_W-1:0];
    assign oe_byte  = !cs_n && !rd_n;
    assign oe_upper = oe_byte && !hben;

    // R8: a lone high byte leaves every writable field untouched
    p_hi_alone_r8: assert property (@(posedge clk) disable iff (rst)
        (stb && hben && !lo_vld) |=> ($stable(ofs_q) && $stable(gain_q)
                                      && $stable(ctrl_q.rptr) && $stable(ctrl_q.bipolar)));

    // R7: a completed word consumes the pending low byte
    p_commit_clears_r7: assert property (@(posedge clk) disable iff (rst)
        commit |=> !lo_vld);

    // R5: the upper pins are only ever driven alongside the low byte
    p_upper_with_byte_r5: assert property (@(posedge clk) disable iff (rst)
        oe_upper |-> (oe_byte && !hben));
endmodule

// File: rtl/sar_bytebus_ctrl.sv
module sar_bytebus_ctrl
    import sbc_pkg::*;
#(
    parameter int RES_W        = 12,
    parameter int CONV_CYCLES  = 18,
    parameter int CAL_FULL_CYC = 125013,
    parameter int CAL_FSG_CYC  = 111124,
    parameter int CAL_OFS_CYC  = 13889
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             convst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             hben,
    input  logic [7:0]       db_in,
    input  logic [RES_W-1:0] sample_code,
    output logic             busy,
    output logic [RES_W-1:0] db_out,
    output logic             db_oe_byte,
    output logic             db_oe_upper
);
    localparam int SW = $clog2(RES_W);

    ctrl_t            ctrl;
    logic             cal_go, conv_start, step_en, res_load, cal_done;
    logic [SW-1:0]    step_pos;
    logic [RES_W-1:0] res_val;

    sbc_seq #(
        .RES_W        (RES_W),
        .CONV_CYCLES  (CONV_CYCLES),
        .CAL_FULL_CYC (CAL_FULL_CYC),
        .CAL_FSG_CYC  (CAL_FSG_CYC),
        .CAL_OFS_CYC  (CAL_OFS_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .convst     (convst),
        .cal_go     (cal_go),
        .cal_mode   (ctrl.cal),
        .busy       (busy),
        .conv_start (conv_start),
        .step_en    (step_en),
        .step_pos   (step_pos),
        .res_load   (res_load),
        .cal_done   (cal_done)
    );

    sbc_sar #(.RES_W(RES_W)) u_sar (
        .clk         (clk),
        .rst         (rst),
        .start       (conv_start),
        .sample_code (sample_code),
        .step_en     (step_en),
        .step_pos    (step_pos),
        .bipolar     (ctrl.bipolar),
        .res_val     (res_val)
    );

    sbc_bytebus #(.RES_W(RES_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .hben     (hben),
        .db_in    (db_in),
        .res_load (res_load),
        .res_val  (res_val),
        .cal_done (cal_done),
        .ctrl_q   (ctrl),
        .cal_go   (cal_go),
        .db_out   (db_out),
        .oe_byte  (db_oe_byte),
        .oe_upper (db_oe_upper)
    );

    // R6: no drive without a selected read
    p_quiet_bus_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> !(db_oe_byte || db_oe_upper));
endmodule

// File: tb/sim_sar_bytebus_ctrl.sv
`timescale 1ns/100ps
module sim_sar_bytebus_ctrl;
    localparam int FULL_C = 60;
    localparam int FSG_C  = 45;
    localparam int OFS_C  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic convst = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hben = 1'b0;
    logic [7:0]  db_in = '0;
    logic [11:0] sample_code = '0;
    logic        busy, db_oe_byte, db_oe_upper;
    logic [11:0] db_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int prev_res = 0;

    always #2.5 clk = ~clk;

    sar_bytebus_ctrl #(
        .CAL_FULL_CYC (FULL_C),
        .CAL_FSG_CYC  (FSG_C),
        .CAL_OFS_CYC  (OFS_C)
    ) u0 (
        .clk(clk), .rst(rst), .convst(convst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .hben(hben), .db_in(db_in), .sample_code(sample_code), .busy(busy),
        .db_out(db_out), .db_oe_byte(db_oe_byte), .db_oe_upper(db_oe_upper)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit h, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; hben = h; db_in = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic write16(input logic [15:0] w);
        wr_byte(1'b0, w[7:0]);
        wr_byte(1'b1, w[15:8]);
    endtask

    task automatic rd(input bit h, output int d, output bit ob, output bit ou);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; hben = h;
        #1;
        d = int'(db_out); ob = db_oe_byte; ou = db_oe_upper;
        cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    endtask

    task automatic do_conv(input int code, input bit bip, input bit glitch);
        int n;
        int last;
        int exp;
        sample_code = code[11:0];
        @(negedge clk);
        convst = 1'b1; cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
        @(negedge clk);
        chk("R1 busy after start edge", int'(busy), 1);
        n = 1;
        last = int'(db_out);
        while (busy && n < 100) begin
            @(negedge clk);
            if (glitch && n == 4) convst = 1'b0;
            if (glitch && n == 6) convst = 1'b1;
            if (n == 8) sample_code = ~code[11:0];
            if (busy) begin
                n++;
                last = int'(db_out);
            end
        end
        exp = bip ? (code ^ 12'h800) : code;
        chk(glitch ? "R12 conversion length with convst toggled" : "R2 conversion length", n, 18);
        chk(glitch ? "R12 result kept from first start" : "R3 R4 result before BUSY falls", last, exp);
        prev_res = exp;
        convst = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic do_cal(input int mode, input int len, input bit poke);
        int n;
        write16(16'(mode << 3));
        cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
        #1;
        chk("R10 busy low on commit cycle", int'(busy), 0);
        chk("R9 control shows calibration mode", int'(db_out), mode << 3);
        @(negedge clk);
        chk("R10 busy high cycle after commit", int'(busy), 1);
        n = 1;
        while (busy && n < 1000) begin
            @(negedge clk);
            if (poke && n == 5) convst = 1'b1;
            if (poke && n == 7) convst = 1'b0;
            if (busy) n++;
        end
        chk("R10 calibration length", n, len);
        chk("R11 mode field cleared at end", int'(db_out), 0);
        cs_n = 1'b1; rd_n = 1'b1;
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk("R12 convst during calibration ignored", int'(busy), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d;
        bit ob, ou;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        chk("R1 busy low after reset", int'(busy), 0);
        rd(1'b0, d, ob, ou);
        chk("R9 control zero after reset", d, 0);
        chk("R5 both enables during 12-bit read", int'({ob, ou}), 3);

        // R6: bus idle unless chip select and read both low
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R6 no drive without chip select", int'({db_oe_byte, db_oe_upper}), 0);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R6 no drive without read", int'({db_oe_byte, db_oe_upper}), 0);
        cs_n = 1'b1;

        // R7, R8, R9: byte assembly and register access
        write16(16'h8000 | 16'h2A5C);
        write16(16'h0002);
        rd(1'b0, d, ob, ou);
        chk("R7 offset register low 12 bits", d, 12'hA5C);
        rd(1'b1, d, ob, ou);
        chk("R5 R9 offset register high byte", d, 8'h2A);
        chk("R5 upper pins released on byte read", int'({ob, ou}), 2);
        wr_byte(1'b1, 8'hFF);
        rd(1'b0, d, ob, ou);
        chk("R8 lone high byte ignored", d, 12'hA5C);
        wr_byte(1'b0, 8'h11);
        wr_byte(1'b0, 8'h22);
        wr_byte(1'b1, 8'h95);
        rd(1'b0, d, ob, ou);
        chk("R8 newest low byte used", d, 12'h522);
        rd(1'b1, d, ob, ou);
        chk("R8 high byte of assembled word", d, 8'h15);
        write16(16'hFFFF);
        write16(16'h0003);
        rd(1'b0, d, ob, ou);
        chk("R7 gain register low 12 bits", d, 12'hFFF);
        rd(1'b1, d, ob, ou);
        chk("R9 gain register is 14 bits", d, 8'h3F);
        write16(16'h0004);
        write16(16'h4123);
        rd(1'b0, d, ob, ou);
        chk("R7 reserved destination discarded", d, 12'h004);
        write16(16'h0002);
        rd(1'b0, d, ob, ou);
        chk("R7 reserved write left offset", d, 12'h522);

        // R1-R4: conversion sweeps in both formats
        write16(16'h0001);
        for (int c = 0; c < 4096; c += 13) do_conv(c, 1'b0, 1'b0);
        do_conv(4095, 1'b0, 1'b0);
        do_conv(2048, 1'b0, 1'b0);
        rd(1'b1, d, ob, ou);
        chk("R5 result high byte", d, 8'h08);
        write16(16'h0005);
        for (int c = 0; c < 4096; c += 13) do_conv(c, 1'b1, 1'b0);
        do_conv(4095, 1'b1, 1'b0);
        do_conv(2047, 1'b1, 1'b0);
        do_conv(2048, 1'b1, 1'b0);

        // R12: convst toggled mid conversion
        do_conv(12'h3C1, 1'b1, 1'b1);

        // R10, R11, R12: calibration sequences
        do_cal(1, FULL_C, 1'b1);
        do_cal(2, FSG_C, 1'b0);
        do_cal(3, OFS_C, 1'b1);
        write16(16'h0005);
        rd(1'b0, d, ob, ou);
        chk("R12 result unchanged after calibration", d, prev_res);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule